// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block is the digital front end of a column (segment) driver for a dot-matrix LCD panel. Display data arrives 4 or 8 bits at a time, qualified by falling edges of a shift clock, and is written into a line latch that holds either 160 or 80 pixels. The write position starts at either the bottom or the top of the line, set by a fill-direction input. A falling edge of a separate line clock copies the complete line into an output-holding latch. Each held pixel, combined with the AC polarity input, picks one of four 2-bit drive-level codes that feed the external level shifters.

Several of these blocks can be chained without an external decoder. Each block accepts data only while its active-low enable is low and drives its active-low carry output low once its line is full, so the carry can enable the next block in the chain. A line-clock falling edge rearms the block and releases the carry, so every new line starts again at the first block.

Both clocks are sampled by the system clock `clk`. Each must stay high for at least one `clk` rising edge and low for at least one before it changes again.

Top module: `lcd_col_loader`

## Requirements
- R1: A shift-clock falling edge writes data only while `en_n` is 0; with `en_n` at 1 the line latch, the load position and `carry_n` are left unchanged.
- R2: With `bus8`=1 each accepted load writes all 8 bits of `din`; with `bus8`=0 it writes only `din[3:0]`, and `din[7:4]` have no effect.
- R3: With `short_line`=0 a line is 160 pixels (40 loads of 4 bits or 20 loads of 8 bits); with `short_line`=1 it is 80 pixels (20 or 10 loads).
- R4: With `fill_rev`=0, bit j of the k-th accepted load (k from 0) goes to pixel k*G+j, where G is the group width (4 or 8).
- R5: With `fill_rev`=1, bit j of the k-th accepted load goes to pixel L-1-(k*G+j), where L is the line length, so the first group fills the top pixels with `din[0]` on the highest one.
- R6: A line-clock falling edge copies the line latch into the output latch; the output latch changes at no other time.
- R7: `carry_n` is 1 until the last load of the line is accepted and is 0 from the following `clk` cycle on.
- R8: A line-clock falling edge sets `carry_n` to 1 and restarts loading at the first group position; a shift-clock edge in the same cycle is ignored.
- R9: Loads that arrive after the line is full are ignored until the next line-clock falling edge.
- R10: Pixel i drives `drv_lvl[2i+1:2i]`, registered one `clk` cycle after the output latch or `ac_pol` changes: code 0 for `ac_pol`=1 and pixel 1, code 2 for `ac_pol`=1 and pixel 0, code 1 for `ac_pol`=0 and pixel 1, code 3 for `ac_pol`=0 and pixel 0.
- R11: Synchronous reset clears both latches, sets `carry_n` to 1 and sets every `drv_lvl` code to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both panel clocks |
| rst | input | 1 | Synchronous active-high reset |
| line_clk | input | 1 | Line clock; its falling edge moves the line to the output latch |
| shift_clk | input | 1 | Shift clock; its falling edge loads one data group |
| en_n | input | 1 | Active-low load enable, from the previous block's carry |
| din | input | 8 | Display data group |
| bus8 | input | 1 | 1: 8-bit groups, 0: 4-bit groups on din[3:0] |
| short_line | input | 1 | 1: 80-pixel line, 0: 160-pixel line |
| fill_rev | input | 1 | 1: fill from the top pixel down, 0: from pixel 0 up |
| ac_pol | input | 1 | AC polarity of the drive waveform |
| carry_n | output | 1 | Active-low carry, low once the line is full |
| drv_lvl | output | 320 | Two-bit drive-level code per pixel |

## Verification
The assertions assume both panel clocks are slow against `clk`, so each level lasts across at least one rising edge and each falling edge shows up as a single-cycle event. They also assume `bus8`, `short_line` and `fill_rev` change only just after a line-clock edge, when the load position is back at zero. The bench drives every panel clock level for a full `clk` period and picks new random modes only right after a line transfer. It mixes disabled loads, loads past a full line, and random upper data bits in 4-bit mode into otherwise random traffic.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;

  typedef enum logic [1:0] {
    LV_ON_POS  = 2'd0,
    LV_ON_NEG  = 2'd1,
    LV_OFF_POS = 2'd2,
    LV_OFF_NEG = 2'd3
  } drv_code_e;

  function automatic drv_code_e pick_level(input logic pix, input logic pol);
    drv_code_e c;
    if (pix) c = pol ? LV_ON_POS : LV_ON_NEG;
    else     c = pol ? LV_OFF_POS : LV_OFF_NEG;
    return c;
  endfunction

endpackage

// File: rtl/lcdl_fall_det.sv
module lcdl_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig;
  end

  assign fall = prev_q & ~sig;
endmodule

// File: rtl/lcdl_line_fill.sv
module lcdl_line_fill #(
  parameter int NOUT = 160,
  parameter int BUSW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_ev,
  input  logic            latch_ev,
  input  logic            en_n,
  input  logic            bus8,
  input  logic            short_line,
  input  logic            fill_rev,
  input  logic [BUSW-1:0] din,
  output logic [NOUT-1:0] line_q,
  output logic            carry_n
);
  localparam int NARROW  = BUSW / 2;
  localparam int MAXGRP  = NOUT / NARROW;
  localparam int CW      = $clog2(MAXGRP + 1);
  localparam int IW      = $clog2(NOUT + 1) + 1;
  localparam int LAST_WF = NOUT / BUSW - 1;
  localparam int LAST_WH = NOUT / (2 * BUSW) - 1;
  localparam int LAST_NF = NOUT / NARROW - 1;
  localparam int LAST_NH = NOUT / (2 * NARROW) - 1;

  logic [CW-1:0] grp_q;
  logic          full_q;
  logic [CW-1:0] last_grp;
  logic [IW-1:0] grp_len;
  logic [IW-1:0] line_len;
  logic [IW-1:0] base;
  logic          accept;
  logic [IW-1:0] idx_a [BUSW];
  logic [BUSW-1:0] wr_bit;

  always_comb begin
    case ({bus8, short_line})
      2'b11:   last_grp = CW'(LAST_WH);
      2'b10:   last_grp = CW'(LAST_WF);
      2'b01:   last_grp = CW'(LAST_NH);
      default: last_grp = CW'(LAST_NF);
    endcase
    grp_len  = bus8 ? IW'(BUSW) : IW'(NARROW);
    line_len = short_line ? IW'(NOUT / 2) : IW'(NOUT);
    base     = IW'(grp_q) * grp_len;
    accept   = load_ev & ~en_n & ~full_q & ~latch_ev;
  end

  for (genvar j = 0; j < BUSW; j++) begin : g_pos
    logic [IW-1:0] pos;
    assign pos       = base + IW'(j);
    assign idx_a[j]  = fill_rev ? (line_len - IW'(1) - pos) : pos;
    assign wr_bit[j] = accept & (IW'(j) < grp_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else begin
      for (int j = 0; j < BUSW; j++) begin
        if (wr_bit[j]) line_q[idx_a[j]] <= din[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q   <= '0;
      full_q  <= 1'b0;
      carry_n <= 1'b1;
    end else if (latch_ev) begin
      grp_q   <= '0;
      full_q  <= 1'b0;
      carry_n <= 1'b1;
    end else if (accept) begin
      if (grp_q == last_grp) begin
        full_q  <= 1'b1;
        carry_n <= 1'b0;
      end else begin
        grp_q <= grp_q + CW'(1);
      end
    end
  end

  a_r1_disabled_no_write: assert property (@(posedge clk) disable iff (rst)
    (load_ev && en_n && !latch_ev) |=> ($stable(line_q) && $stable(carry_n)));

  a_r9_full_no_write: assert property (@(posedge clk) disable iff (rst)
    (load_ev && full_q && !latch_ev) |=> $stable(line_q));

  a_r7_carry_after_load: assert property (@(posedge clk) disable iff (rst)
    $fell(carry_n) |-> $past(load_ev && !en_n));

  a_r8_line_rearm: assert property (@(posedge clk) disable iff (rst)
    latch_ev |=> (carry_n && grp_q == '0));
endmodule

// File: rtl/lcdl_drive_map.sv
module lcdl_drive_map #(
  parameter int NOUT = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NOUT-1:0]   hold,
  input  logic              ac_pol,
  output logic [2*NOUT-1:0] drv_lvl
);
  import lcdl_pkg::*;

  for (genvar i = 0; i < NOUT; i++) begin : g_pix
    always_ff @(posedge clk) begin
      if (rst) drv_lvl[2*i +: 2] <= LV_OFF_NEG;
      else     drv_lvl[2*i +: 2] <= pick_level(hold[i], ac_pol);
    end
  end

  a_r10_on_pixel_low_code: assert property (@(posedge clk) disable iff (rst)
    $past(hold[0]) |-> !drv_lvl[1]);
endmodule

// File: rtl/lcd_col_loader.sv
module lcd_col_loader #(
  parameter int NOUT = 160,
  parameter int BUSW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_clk,
  input  logic              shift_clk,
  input  logic              en_n,
  input  logic [BUSW-1:0]   din,
  input  logic              bus8,
  input  logic              short_line,
  input  logic              fill_rev,
  input  logic              ac_pol,
  output logic              carry_n,
  output logic [2*NOUT-1:0] drv_lvl
);
  logic load_ev;
  logic latch_ev;
  logic [NOUT-1:0] line_q;
  logic [NOUT-1:0] hold_q;

  lcdl_fall_det u_shift_edge (.clk(clk), .rst(rst), .sig(shift_clk), .fall(load_ev));
  lcdl_fall_det u_line_edge  (.clk(clk), .rst(rst), .sig(line_clk),  .fall(latch_ev));

  lcdl_line_fill #(.NOUT(NOUT), .BUSW(BUSW)) u_fill (
    .clk(clk), .rst(rst), .load_ev(load_ev), .latch_ev(latch_ev), .en_n(en_n),
    .bus8(bus8), .short_line(short_line), .fill_rev(fill_rev), .din(din),
    .line_q(line_q), .carry_n(carry_n)
  );

  always_ff @(posedge clk) begin
    if (rst)           hold_q <= '0;
    else if (latch_ev) hold_q <= line_q;
  end

  a_r6_hold_only_on_line_edge: assert property (@(posedge clk) disable iff (rst)
    !latch_ev |=> $stable(hold_q));

  lcdl_drive_map #(.NOUT(NOUT)) u_drive (
    .clk(clk), .rst(rst), .hold(hold_q), .ac_pol(ac_pol), .drv_lvl(drv_lvl)
  );
endmodule

// File: tb/lcd_col_loader_tb_top.sv
module lcd_col_loader_tb_top;
  localparam int NOUT = 160;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_clk = 1'b0, shift_clk = 1'b0, en_n = 1'b1;
  logic [7:0] din = '0;
  logic bus8 = 1'b0, short_line = 1'b0, fill_rev = 1'b0, ac_pol = 1'b0;
  logic carry_n;
  logic [2*NOUT-1:0] drv_lvl;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [NOUT-1:0] mline = '0, mhold = '0;
  int mgrp = 0;
  bit mfull = 0;

  always #5 clk = ~clk;

  lcd_col_loader dut_i (
    .clk(clk), .rst(rst), .line_clk(line_clk), .shift_clk(shift_clk), .en_n(en_n),
    .din(din), .bus8(bus8), .short_line(short_line), .fill_rev(fill_rev),
    .ac_pol(ac_pol), .carry_n(carry_n), .drv_lvl(drv_lvl)
  );

  function automatic logic [1:0] exp_code(input logic pix, input logic pol);
    case ({pol, pix})
      2'b11:   return 2'd0;
      2'b10:   return 2'd2;
      2'b01:   return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [2*NOUT-1:0] exp_lvl(input logic [NOUT-1:0] h, input logic pol);
    logic [2*NOUT-1:0] v;
    for (int i = 0; i < NOUT; i++) v[2*i +: 2] = exp_code(h[i], pol);
    return v;
  endfunction

  function automatic int grp_w();
    return bus8 ? 8 : 4;
  endfunction

  function automatic int line_l();
    return short_line ? NOUT / 2 : NOUT;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_lvl(input string req);
    logic [2*NOUT-1:0] e;
    e = exp_lvl(mhold, ac_pol);
    checks++;
    if (drv_lvl !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, drv_lvl, e);
    end
  endtask

  task automatic do_load(input logic [7:0] d, input bit enabled);
    @(negedge clk);
    shift_clk = 1'b1; din = d; en_n = !enabled;
    @(negedge clk);
    shift_clk = 1'b0;
    @(negedge clk);
    if (enabled && !mfull) begin
      for (int j = 0; j < grp_w(); j++) begin
        int pos;
        pos = mgrp * grp_w() + j;
        if (fill_rev) mline[line_l() - 1 - pos] = d[j];
        else          mline[pos] = d[j];
      end
      if (mgrp == line_l() / grp_w() - 1) mfull = 1;
      else mgrp++;
    end
  endtask

  task automatic do_latch();
    @(negedge clk);
    line_clk = 1'b1;
    @(negedge clk);
    line_clk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mhold = mline; mgrp = 0; mfull = 0;
  endtask

  task automatic fill_line(input int disabled_pct, input int extra);
    int groups;
    groups = line_l() / grp_w();
    for (int k = 0; k < groups; k++) begin
      while (($urandom % 100) < disabled_pct) begin
        do_load(8'($urandom), 0);
        chk_bit("R1 disabled load keeps carry", carry_n, 1'b1);
      end
      do_load(8'($urandom), 1);
      if (k == groups - 1) chk_bit("R7 carry low after last load", carry_n, 1'b0);
      else if (k == groups - 2) chk_bit("R7 carry high before last load", carry_n, 1'b1);
    end
    for (int x = 0; x < extra; x++) begin
      do_load(8'($urandom), 1);
      chk_bit("R9 carry stays low past full", carry_n, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_bit("R11 reset carry", carry_n, 1'b1);
    chk_lvl("R11 reset levels");

    // R4 directed: 8-bit, 160, forward
    bus8 = 1; short_line = 0; fill_rev = 0; ac_pol = 1;
    fill_line(0, 0);
    do_latch();
    chk_bit("R8 carry released", carry_n, 1'b1);
    chk_lvl("R4 R3 forward 8-bit line");
    ac_pol = 0; @(negedge clk);
    chk_lvl("R10 polarity flip");

    // R5 directed: 4-bit, 80, reverse, upper bits random (R2)
    bus8 = 0; short_line = 1; fill_rev = 1;
    fill_line(0, 3);
    do_latch();
    chk_lvl("R5 R2 R9 reverse 4-bit short line");

    // R1 directed: disabled loads interleaved
    bus8 = 0; short_line = 0; fill_rev = 0;
    fill_line(40, 2);
    do_latch();
    chk_lvl("R1 R3 disabled loads ignored");

    // R6: hold stays during a new partial fill
    bus8 = 1; fill_rev = 1;
    for (int k = 0; k < 5; k++) do_load(8'($urandom), 1);
    chk_lvl("R6 hold unchanged by loads");
    do_latch();
    chk_lvl("R8 R6 partial line transferred");

    // R8: restart at first position after partial line
    fill_line(0, 0);
    do_latch();
    chk_lvl("R8 restart from first group");

    // random mix
    for (int t = 0; t < 24; t++) begin
      bus8 = $urandom % 2; short_line = $urandom % 2; fill_rev = $urandom % 2;
      fill_line(20, $urandom % 3);
      ac_pol = $urandom % 2;
      do_latch();
      chk_bit("R8 carry high after line edge", carry_n, 1'b1);
      chk_lvl("R4 R5 R10 random line");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule